// File: doc/BRIEF.md
# ADC Power Sequencing Controller

This block brings the analog sections of an on-chip ADC up and down in a safe order. It drives four enables: the converter clock gate, the bandgap enable, the reference enable and the converter core enable. A two-bit operating-mode request and a one-bit style select steer it. The controller moves step by step towards the requested mode and times each analog settling interval with a down-counter. The counter lengths come from a clock-frequency parameter and microsecond parameters, so one netlist fits any system clock.

The staged style turns on the bandgap and reference first, waits the bandgap settling time, then enables the core and waits the core settling time. The single-step style turns on all three analog enables together and waits only the bandgap settling time. Going down removes one level per clock: core first, then bandgap and reference, then the clock gate.

Conversion requests use a valid/ready pair. `conv_ready` is high only while the block is fully operational and settled. A request is accepted in any cycle where `conv_valid` and `conv_ready` are both high. There is no stall: a request made while `conv_ready` is low is dropped, not held, and is reported with a one-cycle error pulse. The requester need not keep `conv_valid` asserted.

Top module: `adc_pwr_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, all of `adc_clk_en`, `bg_en`, `ref_en`, `core_en`, `conv_ready`, `conv_fire` and `conv_err` are low.
- R2: `core_en` is never high unless both `bg_en` and `ref_en` are high, and `bg_en`/`ref_en` are never high unless `adc_clk_en` is high.
- R3: Staged style (`style_sel`=0), starting from off, with `mode_req` set to 0 before clock edge 0. `adc_clk_en` rises after edge 1, `bg_en` and `ref_en` rise together after edge 2, and `core_en` rises after edge 2+BGR, where BGR = ceil(CLK_HZ*BGR_US/1e6).
- R4: `conv_ready` rises exactly CORE cycles after `core_en` in the staged style, where CORE = ceil(CLK_HZ*max(CORE_US,20)/1e6). A core wait below 20 us is raised to 20 us.
- R5: Single-step style (`style_sel`=1), starting from off, with target mode 0. `bg_en`, `ref_en` and `core_en` rise in the same cycle, one cycle after `adc_clk_en`, and `conv_ready` follows BGR cycles later.
- R6: Mode codes and their settled outputs {clk,bg,ref,core,ready}: 0 = operational {1,1,1,1,1}; 1 = core down {1,1,1,0,0}; 2 = reference down {1,0,0,0,0}; 3 = off {0,0,0,0,0}.
- R7: If `conv_valid` is high when the clock edge samples it and `conv_ready` is high, `conv_fire` is high for the following cycle. If `conv_ready` was low, `conv_fire` stays low and `conv_err` is high for exactly that one cycle.
- R8: When `mode_req` leaves 0 while operational, `conv_ready` and `core_en` fall together after the next clock edge.
- R9: Power-down goes one step per cycle: `core_en` falls first, `bg_en` and `ref_en` fall together one cycle later, and `adc_clk_en` falls one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset; forces off mode |
| mode_req | input | 2 | Requested operating mode (see R6) |
| style_sel | input | 1 | 0 = staged power-up, 1 = single-step power-up |
| conv_valid | input | 1 | Conversion request |
| conv_ready | output | 1 | Converter settled and accepting conversions |
| conv_fire | output | 1 | One-cycle pulse: request accepted |
| conv_err | output | 1 | One-cycle pulse: request refused while not ready |
| adc_clk_en | output | 1 | Converter clock gate enable |
| bg_en | output | 1 | Bandgap enable |
| ref_en | output | 1 | Reference enable |
| core_en | output | 1 | Converter core enable |

## Verification
The assertions check the enable ordering on every cycle: the core never runs without bandgap and reference, nothing analog runs without the clock, and every falling edge comes after the level above it has already dropped. They also check that accept and refuse pulses match the ready flag of the cycle before. The exact settling lengths, the raising of a short core wait to the 20 us floor, the difference between the two styles, and the settled outputs of each mode show only in the bench scenarios. There the cycle of every edge is measured against counts derived from the parameters.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  typedef enum logic [1:0] {
    MODE_RUN    = 2'd0,
    MODE_COREDN = 2'd1,
    MODE_REFDN  = 2'd2,
    MODE_OFF    = 2'd3
  } pwr_mode_e;

  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_CLK      = 3'd1,
    ST_BGWAIT   = 3'd2,
    ST_BGOK     = 3'd3,
    ST_COREWAIT = 3'd4,
    ST_ALLWAIT  = 3'd5,
    ST_OPER     = 3'd6
  } pwr_state_e;

  typedef struct packed {
    logic clk_on;
    logic bg_on;
    logic ref_on;
    logic core_on;
    logic rdy;
  } pwr_out_s;

  // Ceiling of hz*us/1e6, never below one cycle.
  function automatic longint us_to_cyc(longint hz, longint us);
    longint c;
    c = (hz * us + 64'd999999) / 64'd1000000;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic pwr_out_s decode_state(pwr_state_e s);
    pwr_out_s o;
    o = '0;
    case (s)
      ST_OFF:      o = '0;
      ST_CLK:      o = '{clk_on: 1'b1, default: 1'b0};
      ST_BGWAIT,
      ST_BGOK:     o = '{clk_on: 1'b1, bg_on: 1'b1, ref_on: 1'b1, default: 1'b0};
      ST_COREWAIT,
      ST_ALLWAIT:  o = '{clk_on: 1'b1, bg_on: 1'b1, ref_on: 1'b1, core_on: 1'b1, rdy: 1'b0};
      ST_OPER:     o = '1;
      default:     o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/adc_pwr_timer.sv
module adc_pwr_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R3/R4 timing base: an idle counter stays at zero, never wraps
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(expired) && !$past(load)) |-> expired);
endmodule

// File: rtl/adc_pwr_fsm.sv
module adc_pwr_fsm
  import adc_pwr_pkg::*;
#(
  parameter int         W         = 8,
  parameter logic [W-1:0] BGR_LOAD  = '0,
  parameter logic [W-1:0] CORE_LOAD = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  pwr_mode_e    target,
  input  logic         style_sel,
  input  logic         expired,
  output pwr_state_e   state,
  output logic         load,
  output logic [W-1:0] load_val
);
  pwr_state_e nxt;
  logic       want_low;

  assign want_low = (target == MODE_OFF) || (target == MODE_REFDN);

  always_comb begin
    nxt = state;
    case (state)
      ST_OFF:
        if (target != MODE_OFF) nxt = ST_CLK;
      ST_CLK:
        if (target == MODE_OFF)                     nxt = ST_OFF;
        else if (target == MODE_REFDN)              nxt = ST_CLK;
        else if (style_sel && target == MODE_RUN)   nxt = ST_ALLWAIT;
        else                                        nxt = ST_BGWAIT;
      ST_BGWAIT:
        if (want_low)                               nxt = ST_CLK;
        else if (expired && target == MODE_RUN)     nxt = ST_COREWAIT;
        else if (expired)                           nxt = ST_BGOK;
      ST_BGOK:
        if (want_low)                               nxt = ST_CLK;
        else if (target == MODE_RUN)                nxt = ST_COREWAIT;
      ST_COREWAIT:
        if (target != MODE_RUN)                     nxt = ST_BGOK;
        else if (expired)                           nxt = ST_OPER;
      ST_ALLWAIT:
        if (target != MODE_RUN)                     nxt = ST_BGWAIT;
        else if (expired)                           nxt = ST_OPER;
      ST_OPER:
        if (target != MODE_RUN)                     nxt = ST_BGOK;
      default:                                      nxt = ST_OFF;
    endcase
  end

  assign load = (nxt != state) &&
                (nxt == ST_BGWAIT || nxt == ST_COREWAIT || nxt == ST_ALLWAIT);
  assign load_val = (nxt == ST_COREWAIT) ? CORE_LOAD : BGR_LOAD;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= nxt;
  end

  // R4/R5: operation is reached only through a settling wait
  p_oper_after_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OPER && $past(state) != ST_OPER) |->
      ($past(state) == ST_COREWAIT || $past(state) == ST_ALLWAIT));
  // R9: from operation the only exit is core-down
  p_exit_oper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_OPER && state != ST_OPER) |-> state == ST_BGOK);
endmodule

// File: rtl/adc_conv_gate.sv
module adc_conv_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ready,
  input  logic conv_valid,
  output logic conv_fire,
  output logic conv_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_fire <= 1'b0;
      conv_err  <= 1'b0;
    end else begin
      conv_fire <= conv_valid && ready;
      conv_err  <= conv_valid && !ready;
    end
  end

  // R7: accept only when ready was high, refuse only when it was low
  p_fire_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_fire |-> $past(ready));
  p_err_notready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_err |-> !$past(ready));
  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_fire && conv_err));
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter longint CLK_HZ  = 100_000_000,
  parameter longint BGR_US  = 5000,
  parameter longint CORE_US = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_req,
  input  logic       style_sel,
  input  logic       conv_valid,
  output logic       conv_ready,
  output logic       conv_fire,
  output logic       conv_err,
  output logic       adc_clk_en,
  output logic       bg_en,
  output logic       ref_en,
  output logic       core_en
);
  localparam longint CORE_FLOOR_US = 20;
  localparam longint CORE_EFF_US   = (CORE_US < CORE_FLOOR_US) ? CORE_FLOOR_US : CORE_US;
  localparam longint BGR_CYC       = us_to_cyc(CLK_HZ, BGR_US);
  localparam longint CORE_CYC      = us_to_cyc(CLK_HZ, CORE_EFF_US);
  localparam longint MAX_CYC       = (BGR_CYC > CORE_CYC) ? BGR_CYC : CORE_CYC;
  localparam int     CNT_W         = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] BGR_LOAD  = CNT_W'(BGR_CYC - 1);
  localparam logic [CNT_W-1:0] CORE_LOAD = CNT_W'(CORE_CYC - 1);

  pwr_state_e       state;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expired;
  pwr_out_s         outs;

  adc_pwr_fsm #(
    .W(CNT_W), .BGR_LOAD(BGR_LOAD), .CORE_LOAD(CORE_LOAD)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .target(pwr_mode_e'(mode_req)),
    .style_sel(style_sel), .expired(expired),
    .state(state), .load(load), .load_val(load_val)
  );

  adc_pwr_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
  );

  assign outs       = decode_state(state);
  assign adc_clk_en = outs.clk_on;
  assign bg_en      = outs.bg_on;
  assign ref_en     = outs.ref_on;
  assign core_en    = outs.core_on;
  assign conv_ready = outs.rdy;

  adc_conv_gate u_gate (
    .clk(clk), .rst_n(rst_n), .ready(conv_ready),
    .conv_valid(conv_valid), .conv_fire(conv_fire), .conv_err(conv_err)
  );

  // R2: enable hierarchy holds every cycle
  p_core_needs_bgref_r2: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |-> (bg_en && ref_en));
  p_bgref_needs_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_en || ref_en) |-> adc_clk_en);
  // R6: ready implies the full operational set
  p_ready_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_ready |-> (core_en && adc_clk_en));
  // R9: each level falls only after the one above it is already down
  p_bg_falls_late_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bg_en) |-> $past(!core_en));
  p_clk_falls_late_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_clk_en) |-> $past(!bg_en && !ref_en));
  // R8: ready and core drop together
  p_ready_core_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_en) |-> !conv_ready);
endmodule

// File: tb/sim_adc_pwr_seq.sv
module sim_adc_pwr_seq;
  localparam longint HZ = 1_000_000;
  localparam int BGR  = 60;   // BGR_US=60 at 1 MHz
  localparam int CORE = 20;   // CORE_US=8 raised to the 20 us floor

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_req = 2'd3;
  logic style_sel = 1'b0;
  logic conv_valid = 1'b0;
  logic conv_ready, conv_fire, conv_err, adc_clk_en, bg_en, ref_en, core_en;

  int checks = 0;
  int errors = 0;
  int rise_at [5];
  int fall_at [5];

  always #2 clk = ~clk;

  adc_pwr_seq #(.CLK_HZ(HZ), .BGR_US(60), .CORE_US(8)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .style_sel(style_sel),
    .conv_valid(conv_valid), .conv_ready(conv_ready), .conv_fire(conv_fire),
    .conv_err(conv_err), .adc_clk_en(adc_clk_en), .bg_en(bg_en),
    .ref_en(ref_en), .core_en(core_en)
  );

  function automatic logic [4:0] vec();
    return {adc_clk_en, bg_en, ref_en, core_en, conv_ready};
  endfunction

  function automatic logic [4:0] expect_vec(input logic [1:0] m);
    case (m)
      2'd0: return 5'b11111;
      2'd1: return 5'b11100;
      2'd2: return 5'b10000;
      default: return 5'b00000;
    endcase
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Apply a mode at a negedge and record the first rise and fall index of
  // each output; index k means the value seen after clock edge k.
  task automatic trace(input logic [1:0] m, input logic s, input int n);
    logic [4:0] prev;
    for (int b = 0; b < 5; b++) begin rise_at[b] = -1; fall_at[b] = -1; end
    prev = vec();
    mode_req = m; style_sel = s;
    for (int k = 1; k <= n; k++) begin
      logic [4:0] cur;
      @(posedge clk); @(negedge clk);
      cur = vec();
      for (int b = 0; b < 5; b++) begin
        if (cur[b] && !prev[b] && rise_at[b] < 0) rise_at[b] = k;
        if (!cur[b] && prev[b] && fall_at[b] < 0) fall_at[b] = k;
      end
      prev = cur;
    end
  endtask

  // bit order in vec: 4 clk, 3 bg, 2 ref, 1 core, 0 ready
  task automatic conv_try(input string req);
    logic rdy;
    rdy = conv_ready;
    conv_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    conv_valid = 1'b0;
    check({req, " conv_fire"}, conv_fire, rdy);
    check({req, " conv_err"}, conv_err, !rdy);
    @(posedge clk); @(negedge clk);
    check({req, " err one cycle"}, conv_err, 0);
    check({req, " fire one cycle"}, conv_fire, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 outputs in reset", {vec(), conv_fire, conv_err}, 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 outputs after reset", {vec(), conv_fire, conv_err}, 0);
    conv_try("R7 refused while off");

    // R3/R4 staged power-up
    trace(2'd0, 1'b0, BGR + CORE + 10);
    check("R3 clk rise", rise_at[4], 1);
    check("R3 bg rise", rise_at[3], 2);
    check("R3 ref rise", rise_at[2], 2);
    check("R3 core rise", rise_at[1], 2 + BGR);
    check("R4 ready after core", rise_at[0] - rise_at[1], CORE);
    check("R6 operational outputs", vec(), expect_vec(2'd0));
    conv_try("R7 accepted while ready");

    // R8/R9 power-down to off
    trace(2'd3, 1'b0, 6);
    check("R8 ready fall", fall_at[0], 1);
    check("R8 core fall", fall_at[1], 1);
    check("R9 bg fall", fall_at[3], 2);
    check("R9 ref fall", fall_at[2], 2);
    check("R9 clk fall", fall_at[4], 3);
    check("R6 off outputs", vec(), expect_vec(2'd3));

    // R5 single-step power-up
    trace(2'd0, 1'b1, BGR + 10);
    check("R5 clk rise", rise_at[4], 1);
    check("R5 bg rise", rise_at[3], 2);
    check("R5 ref rise", rise_at[2], 2);
    check("R5 core rise", rise_at[1], 2);
    check("R5 ready rise", rise_at[0], 2 + BGR);

    // R8: leaving to core-down
    trace(2'd1, 1'b0, 4);
    check("R8 ready fall to coredown", fall_at[0], 1);
    check("R8 core fall to coredown", fall_at[1], 1);
    check("R6 coredown outputs", vec(), expect_vec(2'd1));
    conv_try("R7 refused in coredown");

    // Constrained random mode walk
    for (int i = 0; i < 30; i++) begin
      logic [1:0] m;
      logic s;
      m = 2'($urandom % 4);
      s = 1'($urandom % 2);
      trace(m, s, BGR + CORE + 8);
      check("R6 random settled outputs", vec(), expect_vec(m));
      check("R2 core implies bg and ref", core_en && !(bg_en && ref_en), 0);
      if ($urandom % 2) conv_try("R7 random request");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule